// File: doc/BRIEF.md
# Raster Timing Meter

This block sits beside a full-raster video stream and works out the stream's timing. On every pixel-clock cycle where the pixel strobe is high, it looks at the horizontal sync, vertical sync, data-enable and field inputs. From these it measures the line and frame totals, the active area, and the sync and porch intervals. It keeps a count of completed frames. It can also flag interlaced input and fix inverted sync polarity by itself. No pixel data passes through the block.

A free-running reference tick, already in the pixel clock domain, defines a fixed measurement window. Over each window the block counts strobed pixels and frame starts, which gives a pixel-rate estimate and a frame-rate estimate. Software reads every result, and turns automatic detection on or off, through a small word-addressed register port. Reads are combinational. Writes take effect at the next clock edge.

All measurements are gathered in working counters. They are copied to the readable set at the start of each frame, so the readable values always belong to a single frame.

Top module: `raster_meter`

## Requirements
- R1: After reset, every readable address (0 to 14) reads zero. This includes the control word, whose bit 0 is the auto-detect enable.
- R2: Address 2 reads the strobed pixels per line, counted from one sync start to the next. Address 3 reads the lines between vertical sync starts, which is the lines per field when the input is interlaced.
- R3: Address 4 reads the data-enable pixels per active line. Address 5 reads the number of lines in a frame that carry any data enable.
- R4: Reads of the interval registers, all counted in pixels or lines:
  - address 7: horizontal front porch
  - address 8: horizontal sync width
  - address 9: horizontal back porch
  - address 10: vertical front porch
  - address 11: vertical sync width
  - address 12: vertical back porch
- R5: Address 6 counts completed frames. The first vertical sync start after reset only opens a frame and does not count.
- R6: The readable measurements change only at a vertical sync start. Status bit 0 (the measurement-valid bit) is set once two consecutive completed frames give identical line and frame totals.
- R7: Cycles with the pixel strobe low are ignored, whatever the sync, enable and field inputs carry.
- R8: When auto-detect is on, a sync input whose high time in one period exceeds its low time is treated as active-low and inverted. Status bit 2 reports this for horizontal sync and status bit 3 for vertical sync. The measurements then match an active-high input.
- R9: When auto-detect is on, status bit 1 is set if either of these changes from one vertical sync start to the next: the horizontal offset of the vertical sync start, or the field input.
- R10: With auto-detect off (control bit 0 cleared), no inversion is applied and status bits 1 to 3 stay zero.
- R11: Address 13 reads the frame starts counted in the last completed reference window, and address 14 reads the strobed pixels in that window. A window is a fixed number of reference ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixValid | input | 1 | Pixel strobe; only cycles with it high are observed |
| hsIn | input | 1 | Horizontal sync, either polarity |
| vsIn | input | 1 | Vertical sync, either polarity |
| deIn | input | 1 | Active-video marker, active high |
| fieldIn | input | 1 | Field identifier for interlaced input |
| refTick | input | 1 | One-cycle tick from the reference clock, already in this domain |
| regAddr | input | 4 | Register word address |
| regWr | input | 1 | Write strobe for the control word |
| regWrData | input | REG_W | Write data |
| regRdData | output | REG_W | Combinational read data for regAddr |

## Verification
The checks assume the following about the input:
- sync and enable change meaning only on strobed cycles;
- each sync period fits the counters;
- vertical sync is aligned to line starts, except where interlace offsets are deliberate.

The directed frames keep to this. They use a fixed 20-by-12 raster with a three-pixel horizontal sync and a two-line vertical sync. Interlace is shown by a half-line vertical sync shift or by a toggling field bit.

Strobe gaps are inserted with scrambled sync and enable values to show that unstrobed cycles are ignored. The rate scenario runs gap-free frames whose length divides the window, so the window always holds the same number of frame starts.

// File: rtl/raster_meter_pkg.sv
package raster_meter_pkg;

  typedef struct packed {
    logic pixEn;
    logic hStart;
    logic hSyncEnd;
    logic deRise;
    logic deOn;
    logic vStart;
    logic vSyncEnd;
  } rmStrobes_t;

  typedef enum logic [3:0] {
    ADDR_CTRL   = 4'd0,
    ADDR_STATUS = 4'd1,
    ADDR_HTOTAL = 4'd2,
    ADDR_VTOTAL = 4'd3,
    ADDR_WIDTH  = 4'd4,
    ADDR_HEIGHT = 4'd5,
    ADDR_FRAMES = 4'd6,
    ADDR_HFRONT = 4'd7,
    ADDR_HSYNC  = 4'd8,
    ADDR_HBACK  = 4'd9,
    ADDR_VFRONT = 4'd10,
    ADDR_VSYNC  = 4'd11,
    ADDR_VBACK  = 4'd12,
    ADDR_FRATE  = 4'd13,
    ADDR_PRATE  = 4'd14
  } rmAddr_t;

endpackage

// File: rtl/raster_meter_ctrl.sv
module raster_meter_ctrl
  import raster_meter_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoEn,
  input  logic       pixValid,
  input  logic       hsIn,
  input  logic       vsIn,
  input  logic       deIn,
  output rmStrobes_t strobes,
  output logic [1:0] invert
);

  logic [1:0] rawSync, prevRaw, fixedSync, prevFixed;
  logic       prevDe;

  assign rawSync = {vsIn, hsIn};

  // One polarity judge per sync line: compare high and low time over a period
  for (genvar i = 0; i < 2; i++) begin : g_pol
    logic [CNT_W-1:0] hiCnt, loCnt;
    logic             invBit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiCnt  <= '0;
        loCnt  <= '0;
        invBit <= 1'b0;
      end else begin
        if (!autoEn) invBit <= 1'b0;
        if (pixValid) begin
          if (rawSync[i] && !prevRaw[i]) begin
            if (autoEn) invBit <= (hiCnt > loCnt);
            hiCnt <= CNT_W'(1);
            loCnt <= '0;
          end else if (rawSync[i]) begin
            hiCnt <= hiCnt + 1'b1;
          end else begin
            loCnt <= loCnt + 1'b1;
          end
        end
      end
    end

    assign invert[i]    = invBit;
    assign fixedSync[i] = rawSync[i] ^ invBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRaw   <= '0;
      prevFixed <= '0;
      prevDe    <= 1'b0;
    end else if (pixValid) begin
      prevRaw   <= rawSync;
      prevFixed <= fixedSync;
      prevDe    <= deIn;
    end
  end

  always_comb begin
    strobes.pixEn    = pixValid;
    strobes.hStart   = pixValid &  fixedSync[0] & ~prevFixed[0];
    strobes.hSyncEnd = pixValid & ~fixedSync[0] &  prevFixed[0];
    strobes.vStart   = pixValid &  fixedSync[1] & ~prevFixed[1];
    strobes.vSyncEnd = pixValid & ~fixedSync[1] &  prevFixed[1];
    strobes.deRise   = pixValid &  deIn & ~prevDe;
    strobes.deOn     = pixValid &  deIn;
  end

  AST_INVERT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !autoEn |=> (invert == 2'b00)); // R10

  AST_POLARITY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn && !(pixValid && hsIn && !prevRaw[0])) |=> $stable(invert[0])); // R8

endmodule

// File: rtl/raster_meter_path.sv
module raster_meter_path
  import raster_meter_pkg::*;
#(
  parameter int H_W   = 12,
  parameter int V_W   = 12,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoEn,
  input  logic             fieldIn,
  input  rmStrobes_t       st,
  output logic [H_W-1:0]   shHTotal,
  output logic [H_W-1:0]   shHSync,
  output logic [H_W-1:0]   shDeStart,
  output logic [H_W-1:0]   shWidth,
  output logic [V_W-1:0]   shVTotal,
  output logic [V_W-1:0]   shVSync,
  output logic [V_W-1:0]   shVDeStart,
  output logic [V_W-1:0]   shHeight,
  output logic [REG_W-1:0] frameCnt,
  output logic             measValid,
  output logic             interlaced
);

  logic [H_W-1:0] hCnt, hPos, deCnt, wHTotal, wHSync, wDeStart, wDeWidth;
  logic [H_W-1:0] newHTotal, newWidth, prevOffset;
  logic [V_W-1:0] vCnt, curLine, actLines, wVSync, wVDeStart, newHeight;
  logic           lineDe, frameDe, seenStart, prevField;

  assign hPos      = st.hStart ? '0 : hCnt;
  assign curLine   = st.vStart ? '0 : (st.hStart ? vCnt : vCnt - 1'b1);
  assign newHTotal = st.hStart ? hCnt : wHTotal;
  assign newWidth  = (st.hStart && lineDe) ? deCnt : wDeWidth;
  assign newHeight = actLines + V_W'(st.hStart & lineDe);

  // Line-level working counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0; deCnt <= '0; lineDe <= 1'b0;
      wHTotal <= '0; wHSync <= '0; wDeStart <= '0; wDeWidth <= '0;
    end else if (st.pixEn) begin
      hCnt <= hPos + 1'b1;
      if (st.hStart) begin
        wHTotal <= hCnt;
        lineDe  <= st.deOn;
        deCnt   <= H_W'(st.deOn);
        if (lineDe) wDeWidth <= deCnt;
      end else begin
        if (st.deOn) lineDe <= 1'b1;
        deCnt <= deCnt + H_W'(st.deOn);
      end
      if (st.hSyncEnd) wHSync <= hPos;
      if (st.deRise && (st.hStart || !lineDe)) wDeStart <= hPos;
    end
  end

  // Frame-level counters, snapshot, frame count and interlace judge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vCnt <= '0; actLines <= '0; frameDe <= 1'b0; wVSync <= '0; wVDeStart <= '0;
      shHTotal <= '0; shHSync <= '0; shDeStart <= '0; shWidth <= '0;
      shVTotal <= '0; shVSync <= '0; shVDeStart <= '0; shHeight <= '0;
      frameCnt <= '0; measValid <= 1'b0; interlaced <= 1'b0;
      seenStart <= 1'b0; prevOffset <= '0; prevField <= 1'b0;
    end else begin
      if (!autoEn) interlaced <= 1'b0;
      if (st.pixEn) begin
        if (st.deRise && (st.vStart || !frameDe)) wVDeStart <= curLine;
        if (st.vSyncEnd) wVSync <= vCnt;
        if (st.vStart) begin
          vCnt       <= V_W'(st.hStart);
          actLines   <= '0;
          frameDe    <= st.deOn;
          shHTotal   <= newHTotal;
          shWidth    <= newWidth;
          shHSync    <= wHSync;
          shDeStart  <= wDeStart;
          shVTotal   <= vCnt;
          shHeight   <= newHeight;
          shVSync    <= wVSync;
          shVDeStart <= wVDeStart;
          measValid  <= seenStart && (newHTotal == shHTotal) && (vCnt == shVTotal);
          if (seenStart) frameCnt <= frameCnt + 1'b1;
          seenStart  <= 1'b1;
          interlaced <= autoEn && seenStart &&
                        ((hPos != prevOffset) || (fieldIn != prevField));
          prevOffset <= hPos;
          prevField  <= fieldIn;
        end else begin
          if (st.deOn) frameDe <= 1'b1;
          if (st.hStart) begin
            vCnt     <= vCnt + 1'b1;
            actLines <= actLines + V_W'(lineDe);
          end
        end
      end
    end
  end

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !st.vStart |=> $stable(frameCnt)); // R5

  AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.vStart |=> ($stable(shHTotal) && $stable(shVTotal) &&
                    $stable(shWidth) && $stable(shHeight))); // R6

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measValid) |-> ((shHTotal == $past(shHTotal)) &&
                          (shVTotal == $past(shVTotal)))); // R6

  AST_INTERLACE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !autoEn |=> !interlaced); // R10

endmodule

// File: rtl/raster_meter.sv
module raster_meter
  import raster_meter_pkg::*;
#(
  parameter int          H_W           = 12,
  parameter int          V_W           = 12,
  parameter int          REG_W         = 32,
  parameter int unsigned WIN_TICKS     = 100_000_000,
  parameter bit          EXT_TELEMETRY = 1'b1,
  parameter bit          RATE_EN       = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             hsIn,
  input  logic             vsIn,
  input  logic             deIn,
  input  logic             fieldIn,
  input  logic             refTick,
  input  logic [3:0]       regAddr,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData
);

  localparam int CNT_W = H_W + V_W;
  localparam int WIN_W = $clog2(WIN_TICKS + 1);

  rmStrobes_t       strobes;
  logic [1:0]       invert;
  logic             autoEn, measValid, interlaced;
  logic [H_W-1:0]   shHTotal, shHSync, shDeStart, shWidth, hFront, hSyncOut, hBack;
  logic [V_W-1:0]   shVTotal, shVSync, shVDeStart, shHeight, vFront, vSyncOut, vBack;
  logic [REG_W-1:0] frameCnt, pixRate, frameRate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      autoEn <= 1'b0;
    else if (regWr && (regAddr == ADDR_CTRL))       autoEn <= regWrData[0];
  end

  raster_meter_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .autoEn(autoEn), .pixValid(pixValid),
    .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn), .strobes(strobes), .invert(invert)
  );

  raster_meter_path #(.H_W(H_W), .V_W(V_W), .REG_W(REG_W)) u_path (
    .clk(clk), .rstN(rstN), .autoEn(autoEn), .fieldIn(fieldIn), .st(strobes),
    .shHTotal(shHTotal), .shHSync(shHSync), .shDeStart(shDeStart), .shWidth(shWidth),
    .shVTotal(shVTotal), .shVSync(shVSync), .shVDeStart(shVDeStart), .shHeight(shHeight),
    .frameCnt(frameCnt), .measValid(measValid), .interlaced(interlaced)
  );

  if (EXT_TELEMETRY) begin : g_ext
    assign hFront   = shHTotal - shDeStart - shWidth;
    assign hSyncOut = shHSync;
    assign hBack    = shDeStart - shHSync;
    assign vFront   = shVTotal - shVDeStart - shHeight;
    assign vSyncOut = shVSync;
    assign vBack    = shVDeStart - shVSync;
  end else begin : g_noext
    assign hFront = '0; assign hSyncOut = '0; assign hBack = '0;
    assign vFront = '0; assign vSyncOut = '0; assign vBack = '0;
  end

  if (RATE_EN) begin : g_rate
    logic [WIN_W-1:0] tickCnt;
    logic [REG_W-1:0] pixAcc, frmAcc;
    logic             winEnd;

    assign winEnd = refTick && (tickCnt == WIN_W'(WIN_TICKS - 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tickCnt <= '0; pixAcc <= '0; frmAcc <= '0; pixRate <= '0; frameRate <= '0;
      end else begin
        if (refTick) tickCnt <= winEnd ? '0 : tickCnt + 1'b1;
        pixAcc <= winEnd ? REG_W'(pixValid)       : pixAcc + REG_W'(pixValid);
        frmAcc <= winEnd ? REG_W'(strobes.vStart) : frmAcc + REG_W'(strobes.vStart);
        if (winEnd) begin
          pixRate   <= pixAcc;
          frameRate <= frmAcc;
        end
      end
    end

    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !winEnd |=> ($stable(pixRate) && $stable(frameRate))); // R11
  end else begin : g_norate
    assign pixRate   = '0;
    assign frameRate = '0;
  end

  always_comb begin
    case (rmAddr_t'(regAddr))
      ADDR_CTRL:   regRdData = REG_W'(autoEn);
      ADDR_STATUS: regRdData = REG_W'({invert, interlaced, measValid});
      ADDR_HTOTAL: regRdData = REG_W'(shHTotal);
      ADDR_VTOTAL: regRdData = REG_W'(shVTotal);
      ADDR_WIDTH:  regRdData = REG_W'(shWidth);
      ADDR_HEIGHT: regRdData = REG_W'(shHeight);
      ADDR_FRAMES: regRdData = frameCnt;
      ADDR_HFRONT: regRdData = REG_W'(hFront);
      ADDR_HSYNC:  regRdData = REG_W'(hSyncOut);
      ADDR_HBACK:  regRdData = REG_W'(hBack);
      ADDR_VFRONT: regRdData = REG_W'(vFront);
      ADDR_VSYNC:  regRdData = REG_W'(vSyncOut);
      ADDR_VBACK:  regRdData = REG_W'(vBack);
      ADDR_FRATE:  regRdData = frameRate;
      ADDR_PRATE:  regRdData = pixRate;
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: tb/raster_meter_bench.sv
`timescale 1ns/1ps
module raster_meter_bench;

  localparam int HT = 20, VT = 12, HS = 3, VS = 2;
  localparam int DE_X0 = 7, DE_W = 10, DE_Y0 = 5, DE_H = 5;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        pixValid = 1'b0, hsIn = 1'b0, vsIn = 1'b0, deIn = 1'b0, fieldIn = 1'b0;
  logic        refTick = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWrData = '0, regRdData;
  int          checks = 0, failures = 0, tickPhase = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tickPhase <= (tickPhase == 3) ? 0 : tickPhase + 1;
    refTick   <= (tickPhase == 3);
  end

  raster_meter #(.WIN_TICKS(120)) u_raster_meter (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .hsIn(hsIn), .vsIn(vsIn),
    .deIn(deIn), .fieldIn(fieldIn), .refTick(refTick), .regAddr(regAddr),
    .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic expectReg(input logic [3:0] a, input logic [31:0] mask,
                           input logic [31:0] exp, input string tag);
    regAddr = a;
    #0.1;
    checks++;
    if ((regRdData & mask) !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, a, regRdData & mask, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; pixValid = 1'b0; regWr = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setAuto(input bit en);
    @(negedge clk);
    regWr = 1'b1; regAddr = 4'd0; regWrData = {31'd0, en};
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic drivePix(input bit v, input bit h, input bit vv, input bit d, input bit f);
    @(negedge clk);
    pixValid = v; hsIn = h; vsIn = vv; deIn = d; fieldIn = f;
  endtask

  task automatic sendFrame(input int vOff, input bit fld, input bit inv, input int gapEvery);
    for (int line = 0; line < VT; line++) begin
      for (int pos = 0; pos < HT; pos++) begin
        int k;
        bit h, vv, d;
        k  = line * HT + pos;
        h  = (pos < HS);
        vv = (k >= vOff) && (k < vOff + VS * HT);
        d  = (line >= DE_Y0) && (line < DE_Y0 + DE_H) && (pos >= DE_X0) && (pos < DE_X0 + DE_W);
        if (gapEvery > 0 && (k % gapEvery) == gapEvery - 1)
          drivePix(1'b0, ~(h ^ inv), ~(vv ^ inv), ~d, ~fld);
        drivePix(1'b1, h ^ inv, vv ^ inv, d, fld);
      end
    end
  endtask

  task automatic testReset();
    resetDut();
    for (int a = 0; a < 15; a++) expectReg(4'(a), 32'hFFFF_FFFF, 32'd0, "R1 reset value");
  endtask

  task automatic testProgressive();
    resetDut();
    setAuto(1'b1);
    sendFrame(0, 1'b0, 1'b0, 7);
    sendFrame(0, 1'b0, 1'b0, 7);
    expectReg(4'd1, 32'h1, 32'd0, "R6 valid clear after one compare");
    sendFrame(0, 1'b0, 1'b0, 7);
    expectReg(4'd1, 32'h1, 32'd1, "R6 valid after equal frames");
    sendFrame(0, 1'b0, 1'b0, 7);
    expectReg(4'd2, 32'hFFFF_FFFF, HT, "R2 line total with gaps R7");
    expectReg(4'd3, 32'hFFFF_FFFF, VT, "R2 frame total");
    expectReg(4'd4, 32'hFFFF_FFFF, DE_W, "R3 active width");
    expectReg(4'd5, 32'hFFFF_FFFF, DE_H, "R3 active height");
    expectReg(4'd6, 32'hFFFF_FFFF, 32'd3, "R5 completed frames");
    expectReg(4'd1, 32'hF, 32'd1, "R9 progressive not interlaced");
    expectReg(4'd7, 32'hFFFF_FFFF, HT - DE_X0 - DE_W, "R4 h front porch");
    expectReg(4'd8, 32'hFFFF_FFFF, HS, "R4 h sync width");
    regAddr = 4'd0;
    @(negedge clk);
    expectReg(4'd9, 32'hFFFF_FFFF, DE_X0 - HS, "R4 h back porch");
    expectReg(4'd10, 32'hFFFF_FFFF, VT - DE_Y0 - DE_H, "R4 v front porch");
    expectReg(4'd11, 32'hFFFF_FFFF, VS, "R4 v sync width");
    expectReg(4'd12, 32'hFFFF_FFFF, DE_Y0 - VS, "R4 v back porch");
  endtask

  task automatic testPolarity();
    resetDut();
    setAuto(1'b1);
    for (int f = 0; f < 5; f++) sendFrame(0, 1'b0, 1'b1, 0);
    expectReg(4'd1, 32'hF, 32'd13, "R8 inverted syncs detected");
    expectReg(4'd8, 32'hFFFF_FFFF, HS, "R8 h sync width after fix");
    expectReg(4'd11, 32'hFFFF_FFFF, VS, "R8 v sync width after fix");
    expectReg(4'd2, 32'hFFFF_FFFF, HT, "R8 line total after fix");
  endtask

  task automatic testAutoOff();
    resetDut();
    setAuto(1'b0);
    for (int f = 0; f < 4; f++) sendFrame(0, f[0], 1'b1, 0);
    expectReg(4'd1, 32'hE, 32'd0, "R10 no inversion or interlace flag");
    expectReg(4'd8, 32'hFFFF_FFFF, HT - HS, "R10 raw polarity used for h sync");
    expectReg(4'd11, 32'hFFFF_FFFF, VT - VS, "R10 raw polarity used for v sync");
  endtask

  task automatic testInterlaceOffset();
    resetDut();
    setAuto(1'b1);
    for (int f = 0; f < 4; f++) sendFrame(f[0] ? HT / 2 : 0, 1'b0, 1'b0, 0);
    expectReg(4'd1, 32'h2, 32'd2, "R9 interlace by sync offset");
  endtask

  task automatic testInterlaceField();
    resetDut();
    setAuto(1'b1);
    for (int f = 0; f < 4; f++) sendFrame(0, f[0], 1'b0, 0);
    expectReg(4'd1, 32'h2, 32'd2, "R9 interlace by field bit");
    expectReg(4'd3, 32'hFFFF_FFFF, VT, "R2 lines per field");
  endtask

  task automatic testRate();
    resetDut();
    setAuto(1'b1);
    for (int f = 0; f < 7; f++) sendFrame(0, 1'b0, 1'b0, 0);
    expectReg(4'd13, 32'hFFFF_FFFF, 32'd2, "R11 frames per window");
    expectReg(4'd14, 32'hFFFF_FFFF, 32'd480, "R11 pixels per window");
  endtask

  initial begin
    testReset();
    testProgressive();
    testPolarity();
    testAutoOff();
    testInterlaceOffset();
    testInterlaceField();
    testRate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule